// File: doc/BRIEF.md
# Two-Level Over-Current Breaker

This block decides, for each of four switched supplies, when an over-current must turn off that supply's gate drive. Each channel receives two comparator flags that are already synchronized to the clock. The first flag is a low-level flag that reports a sense-resistor drop above 25 mV. The second is a quick flag whose analog threshold is set by a per-channel configuration field.

The low flag has to stay high for a programmed filter delay before it trips the channel. The delay is counted in ticks of a 1 µs enable input. The quick flag trips the channel on the next clock edge, unless that channel's quick-trip field is set to off. Once a trip happens it is latched until the power-on sequencing logic withdraws the channel enable.

The block drives a per-channel gate enable and a per-channel latched trip status. It also drives one combined fault output, whose active level is programmable. A force-shutdown input, also of programmable polarity, turns off every gate enable at once without going through a clock edge.

Top module: `oc_breaker`

## Requirements
- R1: While `rst_n` is low, every `oc_trip` bit is 0 and `cb_fault` sits at its inactive level (the inverse of `fault_pol`).
- R2: With `tick_us` high, a channel's low flag trips the channel at the end of the clock cycle that holds the Nth consecutive tick with the flag high. N is 25, 50, 100 or 200 for `dly_sel` codes 00, 01, 10 and 11. The trip is visible at `oc_trip` one register after that edge. After N-1 such ticks there is no trip.
- R3: If the low flag goes low for a single clock cycle, the delay count restarts from zero. A full N further ticks are then needed before the channel trips.
- R4: The delay count advances only on clock edges where `tick_us` is high. With `tick_us` held low, a continuously high low flag never trips the channel.
- R5: Channel i takes its quick-trip field from `qt_cfg[2i+1:2i]`. The codes are 01 = 75 mV, 10 = 100 mV and 11 = 150 mV. With any nonzero code, a high `oc_quick[i]` sets `oc_trip[i]` at the next clock edge.
- R6: When a channel's quick-trip field is 00 (off), its `oc_quick` flag has no effect on that channel's trip.
- R7: A trip stays latched after both flags return low. It is cleared by a clock edge with `ch_en[i]` low. `gate_en[i]` is high only when `ch_en[i]` is high, the channel is not tripped and force-shutdown is inactive.
- R8: `cb_fault` equals `fault_pol` when any channel is tripped, and equals its inverse otherwise (`fault_pol` = 0 selects active-low).
- R9: Force-shutdown is active when `fsd_in` equals `fsd_pol`. While it is active, every `gate_en` bit is 0 without waiting for a clock edge.
- R10: A trip on one channel leaves the gate enables and trip status of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | 1 µs tick enable for the delay counters |
| dly_sel | input | 2 | Filter delay code shared by all channels |
| qt_cfg | input | 8 | Quick-trip level, 2 bits per channel |
| fault_pol | input | 1 | Active level of `cb_fault` (1 = active high) |
| fsd_in | input | 1 | Force-shutdown input |
| fsd_pol | input | 1 | Active level of `fsd_in` |
| ch_en | input | 4 | Per-channel enable from power-on sequencing; low clears the trip |
| oc_low | input | 4 | Synchronized over-25 mV flag per channel |
| oc_quick | input | 4 | Synchronized quick-trip flag per channel |
| gate_en | output | 4 | Per-channel gate drive enable |
| oc_trip | output | 4 | Per-channel latched over-current status |
| cb_fault | output | 1 | Combined fault, polarity set by `fault_pol` |

## Verification
The delay filter is driven with continuous low-flag pulses one tick shorter than, and exactly equal to, each of the four programmed delays. This separates an off-by-one error in the counter limit from a wrong decode of the delay code.

A pulse broken by a single low cycle shows whether the counter really restarts or only pauses. A long pulse with the tick held low shows that counting is gated by the tick and not by the clock.

Quick flags are applied on channels with a nonzero level and on a channel whose level is off. This distinguishes the immediate path from the disable decode. The latched trips are then used to exercise fault polarity, force-shutdown polarity and channel isolation.

// File: rtl/oc_brk_pkg.sv
package oc_brk_pkg;
  localparam int unsigned DLY_W = 2;
  localparam int unsigned QT_W  = 2;

  typedef logic [DLY_W-1:0] dly_code_t;

  typedef enum logic [QT_W-1:0] {
    QT_OFF = 2'b00,
    QT_LO  = 2'b01,
    QT_MID = 2'b10,
    QT_HI  = 2'b11
  } qt_level_e;
endpackage

// File: rtl/oc_delay_filter.sv
module oc_delay_filter #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             arm,
  input  logic             flag,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  // Expiry on the tick that completes the programmed count
  always_comb begin
    expire = arm && flag && tick_en && (cnt_inc >= {1'b0, limit});
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || !flag) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (expire) cnt_d = '0;
      else        cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FLAG_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> (cnt_q == '0)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && flag && !tick_en) |=> $stable(cnt_q)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_TICKS)); // R2
endmodule

// File: rtl/oc_trip_latch.sv
module oc_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic slow_hit,
  input  logic quick_hit,
  output logic trip
);
  logic trip_q;
  logic trip_d;

  always_comb begin
    if (!ch_en) trip_d = 1'b0;
    else        trip_d = trip_q || slow_hit || quick_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip = trip_q;

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !trip_q); // R7
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && ch_en) |=> trip_q); // R7
  AST_TRIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(slow_hit || quick_hit)); // R5
endmodule

// File: rtl/oc_fault_drive.sv
module oc_fault_drive #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] trip,
  input  logic              fault_pol,
  input  logic              fsd_in,
  input  logic              fsd_pol,
  output logic [NUM_CH-1:0] gate_en,
  output logic              cb_fault
);
  logic fsd_act;
  logic any_trip;

  always_comb begin
    fsd_act  = (fsd_in == fsd_pol);
    any_trip = |trip;
    cb_fault = any_trip ? fault_pol : !fault_pol;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
    assign gate_en[g] = ch_en[g] && !trip[g] && !fsd_act;
  end
endmodule

// File: rtl/oc_breaker.sv
module oc_breaker #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned BASE_TICKS = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_us,
  input  logic [1:0]          dly_sel,
  input  logic [2*NUM_CH-1:0] qt_cfg,
  input  logic                fault_pol,
  input  logic                fsd_in,
  input  logic                fsd_pol,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH-1:0]   oc_low,
  input  logic [NUM_CH-1:0]   oc_quick,
  output logic [NUM_CH-1:0]   gate_en,
  output logic [NUM_CH-1:0]   oc_trip,
  output logic                cb_fault
);
  import oc_brk_pkg::*;

  localparam int unsigned MAX_TICKS = BASE_TICKS << 3;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  dly_code_t        dly_code;
  logic [CNT_W-1:0] limit;
  logic [NUM_CH-1:0] slow_hit;
  logic [NUM_CH-1:0] quick_hit;
  logic [NUM_CH-1:0] arm;

  // Shared delay limit: base count doubled per code step
  always_comb begin
    dly_code = dly_sel;
    limit    = CNT_W'(BASE_TICKS) << dly_code;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qt_level_e lvl;
    assign lvl          = qt_level_e'(qt_cfg[QT_W*i +: QT_W]);
    assign quick_hit[i] = oc_quick[i] && (lvl != QT_OFF);
    assign arm[i]       = ch_en[i] && !oc_trip[i];

    oc_delay_filter #(
      .CNT_W     (CNT_W),
      .MAX_TICKS (MAX_TICKS)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_us),
      .arm     (arm[i]),
      .flag    (oc_low[i]),
      .limit   (limit),
      .expire  (slow_hit[i])
    );

    oc_trip_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_en     (ch_en[i]),
      .slow_hit  (slow_hit[i]),
      .quick_hit (quick_hit[i]),
      .trip      (oc_trip[i])
    );

    AST_QT_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == QT_OFF && !slow_hit[i] && !oc_trip[i]) |=> !oc_trip[i]); // R6
  end

  oc_fault_drive #(
    .NUM_CH (NUM_CH)
  ) u_drive (
    .ch_en     (ch_en),
    .trip      (oc_trip),
    .fault_pol (fault_pol),
    .fsd_in    (fsd_in),
    .fsd_pol   (fsd_pol),
    .gate_en   (gate_en),
    .cb_fault  (cb_fault)
  );

  AST_FSD_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fsd_in == fsd_pol) |-> (gate_en == '0)); // R9
  AST_IDLE_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip == '0) |-> (cb_fault != fault_pol)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (oc_trip == '0)); // R1
endmodule

// File: tb/tb_oc_breaker.sv
module tb_oc_breaker;
  logic       clk;
  logic       rst_n;
  logic       tick_us;
  logic [1:0] dly_sel;
  logic [7:0] qt_cfg;
  logic       fault_pol;
  logic       fsd_in;
  logic       fsd_pol;
  logic [3:0] ch_en;
  logic [3:0] oc_low;
  logic [3:0] oc_quick;
  logic [3:0] gate_en;
  logic [3:0] oc_trip;
  logic       cb_fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  oc_breaker dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .dly_sel(dly_sel),
    .qt_cfg(qt_cfg), .fault_pol(fault_pol), .fsd_in(fsd_in), .fsd_pol(fsd_pol),
    .ch_en(ch_en), .oc_low(oc_low), .oc_quick(oc_quick),
    .gate_en(gate_en), .oc_trip(oc_trip), .cb_fault(cb_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {dly code, high ticks, expected trip}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 8'd24,  1'b0}, {2'd0, 8'd25,  1'b1},
    {2'd1, 8'd49,  1'b0}, {2'd1, 8'd50,  1'b1},
    {2'd2, 8'd99,  1'b0}, {2'd2, 8'd100, 1'b1},
    {2'd3, 8'd199, 1'b0}, {2'd3, 8'd200, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic rearm(input int ch);
    @(negedge clk); ch_en[ch] = 1'b0;
    @(negedge clk); ch_en[ch] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_us = 1; dly_sel = 0; qt_cfg = 0; fault_pol = 0;
    fsd_in = 0; fsd_pol = 1; ch_en = 0; oc_low = 0; oc_quick = 0;
    repeat (3) @(negedge clk);
    check("R1 trip at reset", {4'b0, oc_trip}, 8'h0);
    check("R1 fault idle at reset", {7'b0, cb_fault}, 8'h1);
    rst_n = 1;
    @(negedge clk); ch_en = 4'hF;
    @(negedge clk);
    check("R7 gates on when enabled", {4'b0, gate_en}, 8'h0F);

    // R2: delay filter table
    for (int v = 0; v < 8; v++) begin
      dly_sel = VEC[v][10:9];
      rearm(0);
      oc_low[0] = 1'b1;
      repeat (int'(VEC[v][8:1])) @(negedge clk);
      oc_low[0] = 1'b0;
      @(negedge clk);
      check($sformatf("R2 vec%0d trip", v), {7'b0, oc_trip[0]}, {7'b0, VEC[v][0]});
      check($sformatf("R2 vec%0d gate", v), {7'b0, gate_en[0]}, {7'b0, !VEC[v][0]});
    end

    // R3: one low cycle restarts the count
    dly_sel = 0;
    rearm(0);
    oc_low[0] = 1'b1; repeat (20) @(negedge clk);
    oc_low[0] = 1'b0; @(negedge clk);
    oc_low[0] = 1'b1; repeat (20) @(negedge clk);
    check("R3 no trip after broken pulse", {7'b0, oc_trip[0]}, 8'h0);
    repeat (5) @(negedge clk);
    check("R3 trip after full restart", {7'b0, oc_trip[0]}, 8'h1);
    oc_low[0] = 1'b0;

    // R4: counting gated by tick
    rearm(0);
    tick_us = 1'b0; oc_low[0] = 1'b1;
    repeat (300) @(negedge clk);
    check("R4 no trip without tick", {7'b0, oc_trip[0]}, 8'h0);
    tick_us = 1'b1;
    repeat (24) @(negedge clk);
    check("R4 no trip at 24 ticks", {7'b0, oc_trip[0]}, 8'h0);
    @(negedge clk);
    check("R4 trip at 25 ticks", {7'b0, oc_trip[0]}, 8'h1);
    oc_low[0] = 1'b0;
    rearm(0);
    @(negedge clk);

    // R5/R6/R10: quick paths
    qt_cfg = 8'b11_00_01_00;
    oc_quick[2] = 1'b1; repeat (5) @(negedge clk); oc_quick[2] = 1'b0;
    check("R6 quick off ignored", {7'b0, oc_trip[2]}, 8'h0);
    oc_quick[1] = 1'b1; @(negedge clk); oc_quick[1] = 1'b0;
    check("R5 quick 75mV trips ch1", {7'b0, oc_trip[1]}, 8'h1);
    check("R10 other channels unaffected", {4'b0, gate_en}, 8'h0D);
    @(negedge clk);
    check("R7 trip latched after flag low", {7'b0, oc_trip[1]}, 8'h1);

    // R8 polarity with a trip present
    fault_pol = 1'b0; #1;
    check("R8 active-low fault", {7'b0, cb_fault}, 8'h0);
    fault_pol = 1'b1; #1;
    check("R8 active-high fault", {7'b0, cb_fault}, 8'h1);

    // R9 force shutdown
    fsd_pol = 1'b1; fsd_in = 1'b1; #1;
    check("R9 force active high clamps", {4'b0, gate_en}, 8'h00);
    fsd_pol = 1'b0; #1;
    check("R9 force inactive by polarity", {4'b0, gate_en}, 8'h0D);
    fsd_in = 1'b0; #1;
    check("R9 force active low clamps", {4'b0, gate_en}, 8'h00);
    fsd_pol = 1'b1;
    @(negedge clk);

    oc_quick[3] = 1'b1; @(negedge clk); oc_quick[3] = 1'b0;
    check("R5 quick 150mV trips ch3", {4'b0, oc_trip}, 8'h0A);

    // R7 clear via enable
    ch_en = 4'h0; @(negedge clk); ch_en = 4'hF; @(negedge clk);
    check("R7 trips cleared", {4'b0, oc_trip}, 8'h00);
    check("R8 idle level active-high", {7'b0, cb_fault}, 8'h0);
    check("R7 gates restored", {4'b0, gate_en}, 8'h0F);

    done = 1;
    report();
    $finish;
  end
endmodule